// File: doc/BRIEF.md
# Pixel-Pair Probe Template Scorer

This block scores a set of object templates at every position of a sliding window over a stream of 12-bit pixels. Each template is a sparse list of probes. A probe is a pair of pixel coordinates inside the window, placed on either side of the expected outline of an object. A probe fires when its two pixels differ by more than a run-time threshold. For each window position the block reports, per template, how many of that template's probes fired. Dividing that count by the template's probe count gives the match fraction.

Pixels arrive one window column at a time, two pixels per 32-bit input word, at one word per clock. The probe list and the template membership of each probe are build-time constants in the package. A probe that belongs to several templates is evaluated once, and its result feeds the adder tree of every template that uses it. All template counts leave together under a single valid strobe. Picking the best template is left to downstream logic.

Top module: `probe_scorer`

## Requirements
- R1: Synchronous active-high reset clears `out_valid` to 0, all counts to 0 and the threshold register to 0.
- R2: A window column of WIN_ROWS pixels is delivered as WORDS_PER_COL consecutive accepted words (those with `in_valid` high). Word k carries row 2k in bits 11:0 and row 2k+1 in bits 27:16. Bits 15:12 and 31:28 are ignored. Cycles with `in_valid` low change nothing, whatever the other inputs hold.
- R3: Each completed column enters the window as its newest column, and the oldest column is dropped. Probe coordinates are (row, column), with column 0 the oldest of the WIN_COLS columns held.
- R4: With d = pixel B minus pixel A as a signed difference, a probe fires when d > threshold or d < -threshold. Both comparisons are strict, so |d| equal to the threshold does not fire.
- R5: Template t's count is the number of fired probes whose membership bit t is set. A probe shared by several templates adds one to each of them.
- R6: A window position is scored once every column from the first row-start column on is complete. Its counts and `out_valid` appear together, for one cycle, 3 clock cycles after the edge that accepts the final word of the completing column. Every scored position is reported.
- R7: An accepted word with `in_row_start` high begins a new image row and is taken as word 0 of column 0. No new window is scored until WIN_COLS columns of the new row are complete. Results already in the pipeline still emerge.
- R8: Writing `thr_data` with `thr_we` high updates the threshold. The new value applies to every window whose final word is accepted in the same cycle as the write or later.
- R9: Each count is CNT_W bits wide, enough for the largest template size. When every probe of the largest template fires, the full count is reported without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_row_start | input | 1 | Accepted word is the first word of a new image row |
| in_word | input | 32 | Two pixels of the current column |
| thr_we | input | 1 | Threshold write enable |
| thr_data | input | 12 | New threshold value |
| out_valid | output | 1 | Counts are valid for one window position |
| out_count | output | NUM_TPL*CNT_W | Per-template fired-probe counts, template t at bits t*CNT_W upward |

## Verification
Every scored window yields its counts three cycles after the edge that accepts the last word of its newest column. The bench computes the expected counts from its own pixel image when it drives that word, queues them, and compares them in order at falling edges whenever `out_valid` is high. A strobe with nothing queued counts as a failure. One directed probe counts the edges after the completing word and checks that `out_valid` is still low after the second edge and high after the third. Threshold changes are made either while the pipeline is idle or on the completing word itself, so every expected value is tied to a known threshold.

// File: rtl/probe_pkg.sv
package probe_pkg;

    // Pixel and word geometry
    localparam int PIX_W         = 12;
    localparam int WORD_W        = 32;
    localparam int LANE_W        = 16;
    localparam int PIX_PER_WORD  = WORD_W / LANE_W;

    // Window geometry
    localparam int WIN_ROWS      = 4;
    localparam int WIN_COLS      = 4;
    localparam int WORDS_PER_COL = (WIN_ROWS + PIX_PER_WORD - 1) / PIX_PER_WORD;

    // Probe set
    localparam int NUM_TPL    = 3;
    localparam int NUM_PROBES = 6;
    localparam int COORD_W    = 4;

    typedef struct packed {
        logic [COORD_W-1:0] ra;       // row of pixel A
        logic [COORD_W-1:0] ca;       // column of pixel A (0 = oldest)
        logic [COORD_W-1:0] rb;       // row of pixel B
        logic [COORD_W-1:0] cb;       // column of pixel B
        logic [NUM_TPL-1:0] members;  // bit t set: probe belongs to template t
    } probe_t;

    // Each unique probe listed once; sharing is expressed by the member mask.
    localparam probe_t PROBE_TABLE [NUM_PROBES] = '{
        '{ra: 4'd0, ca: 4'd0, rb: 4'd0, cb: 4'd3, members: 3'b011},
        '{ra: 4'd1, ca: 4'd1, rb: 4'd2, cb: 4'd1, members: 3'b001},
        '{ra: 4'd3, ca: 4'd0, rb: 4'd3, cb: 4'd2, members: 3'b111},
        '{ra: 4'd2, ca: 4'd3, rb: 4'd1, cb: 4'd0, members: 3'b010},
        '{ra: 4'd0, ca: 4'd2, rb: 4'd3, cb: 4'd3, members: 3'b100},
        '{ra: 4'd1, ca: 4'd3, rb: 4'd2, cb: 4'd2, members: 3'b101}
    };

    function automatic int tpl_size(input int t);
        int n;
        n = 0;
        for (int p = 0; p < NUM_PROBES; p++) begin
            if (PROBE_TABLE[p].members[t]) n++;
        end
        return n;
    endfunction

    function automatic int max_tpl_size();
        int m;
        m = 0;
        for (int t = 0; t < NUM_TPL; t++) begin
            if (tpl_size(t) > m) m = tpl_size(t);
        end
        return m;
    endfunction

    localparam int CNT_W = $clog2(max_tpl_size() + 1);

    typedef logic [PIX_W-1:0]                             pix_t;
    typedef logic [WIN_ROWS-1:0][PIX_W-1:0]               col_t;
    typedef logic [WIN_COLS-1:0][WIN_ROWS-1:0][PIX_W-1:0] win_t;

endpackage

// File: rtl/column_window.sv
module column_window
    import probe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_row_start,
    input  logic [WORD_W-1:0] in_word,
    output win_t              win,
    output logic              win_vld
);

    localparam int IDX_W  = (WORDS_PER_COL > 1) ? $clog2(WORDS_PER_COL) : 1;
    localparam int CCNT_W = $clog2(WIN_COLS + 1);

    logic [IDX_W-1:0]  word_idx;
    logic [IDX_W-1:0]  eff_idx;
    logic [CCNT_W-1:0] col_cnt;
    logic [CCNT_W-1:0] cnt_base;
    logic [CCNT_W-1:0] cnt_next;
    col_t              col_buf;
    col_t              col_next;
    logic              col_done;

    // Pad bits of each lane carry no pixel data.
    logic unused_pad;
    assign unused_pad = ^{in_word[LANE_W-1:PIX_W], in_word[WORD_W-1:LANE_W+PIX_W]};

    always_comb begin
        eff_idx  = in_row_start ? '0 : word_idx;
        col_next = col_buf;
        for (int r = 0; r < WIN_ROWS; r++) begin
            if (int'(eff_idx) == r / PIX_PER_WORD) begin
                col_next[r] = in_word[(r % PIX_PER_WORD) * LANE_W +: PIX_W];
            end
        end
        col_done = in_valid && (int'(eff_idx) == WORDS_PER_COL - 1);
        cnt_base = in_row_start ? '0 : col_cnt;
        cnt_next = (int'(cnt_base) == WIN_COLS) ? cnt_base : cnt_base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_idx <= '0;
            col_cnt  <= '0;
            col_buf  <= '0;
            win      <= '0;
            win_vld  <= 1'b0;
        end else begin
            win_vld <= 1'b0;
            if (in_valid) begin
                col_buf <= col_next;
                if (col_done) begin
                    word_idx <= '0;
                    col_cnt  <= cnt_next;
                    win_vld  <= (int'(cnt_next) == WIN_COLS);
                    for (int c = 0; c < WIN_COLS - 1; c++) begin
                        win[c] <= win[c+1];
                    end
                    win[WIN_COLS-1] <= col_next;
                end else begin
                    word_idx <= eff_idx + 1'b1;
                    col_cnt  <= cnt_base;
                end
            end
        end
    end

endmodule

// File: rtl/probe_fire_bank.sv
module probe_fire_bank
    import probe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  win_t                  win,
    input  logic                  win_vld,
    input  pix_t                  thr,
    output logic [NUM_PROBES-1:0] fire,
    output logic                  fire_vld
);

    logic signed [PIX_W:0]  thr_pos;
    logic signed [PIX_W:0]  thr_neg;
    logic [NUM_PROBES-1:0]  hit;

    assign thr_pos = $signed({1'b0, thr});
    assign thr_neg = -thr_pos;

    // One comparator pair per unique probe; templates share the result.
    for (genvar p = 0; p < NUM_PROBES; p++) begin : g_probe
        localparam int RA = int'(PROBE_TABLE[p].ra);
        localparam int CA = int'(PROBE_TABLE[p].ca);
        localparam int RB = int'(PROBE_TABLE[p].rb);
        localparam int CB = int'(PROBE_TABLE[p].cb);

        logic signed [PIX_W:0] diff;
        assign diff   = $signed({1'b0, win[CB][RB]}) - $signed({1'b0, win[CA][RA]});
        assign hit[p] = (diff > thr_pos) || (diff < thr_neg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fire     <= '0;
            fire_vld <= 1'b0;
        end else begin
            fire     <= hit;
            fire_vld <= win_vld;
        end
    end

endmodule

// File: rtl/template_counter.sv
module template_counter
    import probe_pkg::*;
#(
    parameter int TPL = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PROBES-1:0] fire,
    output logic [CNT_W-1:0]      count
);

    localparam int HALF = NUM_PROBES / 2;

    function automatic logic [NUM_PROBES-1:0] member_mask();
        logic [NUM_PROBES-1:0] m;
        for (int p = 0; p < NUM_PROBES; p++) begin
            m[p] = PROBE_TABLE[p].members[TPL];
        end
        return m;
    endfunction

    localparam logic [NUM_PROBES-1:0] MASK = member_mask();

    logic [NUM_PROBES-1:0] sel;
    logic [CNT_W-1:0]      lo_c, hi_c;
    logic [CNT_W-1:0]      lo_q, hi_q;

    assign sel = fire & MASK;

    // First tree level: two partial sums over the low and high probe halves.
    always_comb begin
        lo_c = '0;
        hi_c = '0;
        for (int p = 0; p < NUM_PROBES; p++) begin
            if (p < HALF) lo_c = lo_c + CNT_W'(sel[p]);
            else          hi_c = hi_c + CNT_W'(sel[p]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            hi_q  <= '0;
            count <= '0;
        end else begin
            lo_q  <= lo_c;
            hi_q  <= hi_c;
            count <= lo_q + hi_q;
        end
    end

endmodule

// File: rtl/probe_scorer.sv
module probe_scorer
    import probe_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_row_start,
    input  logic [WORD_W-1:0]        in_word,
    input  logic                     thr_we,
    input  logic [PIX_W-1:0]         thr_data,
    output logic                     out_valid,
    output logic [NUM_TPL*CNT_W-1:0] out_count
);

    win_t                  win;
    logic                  win_vld;
    pix_t                  thr_q;
    logic [NUM_PROBES-1:0] fire;
    logic                  fire_vld;
    logic                  sum_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (thr_we) begin
            thr_q <= thr_data;
        end
    end

    column_window u_win (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_row_start (in_row_start),
        .in_word      (in_word),
        .win          (win),
        .win_vld      (win_vld)
    );

    probe_fire_bank u_fire (
        .clk      (clk),
        .rst      (rst),
        .win      (win),
        .win_vld  (win_vld),
        .thr      (thr_q),
        .fire     (fire),
        .fire_vld (fire_vld)
    );

    for (genvar t = 0; t < NUM_TPL; t++) begin : g_tpl
        template_counter #(.TPL(t)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .fire  (fire),
            .count (out_count[t*CNT_W +: CNT_W])
        );
    end

    // Valid follows the two adder-tree register levels.
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_vld   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            sum_vld   <= fire_vld;
            out_valid <= sum_vld;
        end
    end

endmodule

// File: rtl/probe_scorer_chk.sv
module probe_scorer_chk
    import probe_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_row_start,
    input logic                     win_vld,
    input logic                     out_valid,
    input logic [NUM_TPL*CNT_W-1:0] out_count
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: reset leaves the output idle and zero
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_count == '0));

    // R6: result strobe trails the window strobe by exactly three cycles
    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(win_vld, 3)));

    // R7: a row start never completes a window in the next cycle
    assert_row_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_row_start) |=> !win_vld);

    // R9: no template count exceeds its probe count
    for (genvar t = 0; t < NUM_TPL; t++) begin : g_bound
        localparam int LIM = tpl_size(t);
        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (int'(out_count[t*CNT_W +: CNT_W]) <= LIM));
    end

endmodule

bind probe_scorer probe_scorer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_row_start (in_row_start),
    .win_vld      (win_vld),
    .out_valid    (out_valid),
    .out_count    (out_count)
);

// File: tb/probe_scorer_tb.sv
module probe_scorer_tb;
    import probe_pkg::*;

    localparam int IMG_COLS = 8;
    localparam int MAX_Q    = 64;
    localparam int NVEC     = 7;

    // Vector: {threshold[11:0], pattern[3:0], gap}
    localparam logic [16:0] VEC [NVEC] = '{
        {12'd0,    4'd1, 1'b0},
        {12'd100,  4'd1, 1'b1},
        {12'd0,    4'd2, 1'b0},
        {12'd4094, 4'd2, 1'b0},
        {12'd4095, 4'd2, 1'b1},
        {12'd300,  4'd3, 1'b0},
        {12'd700,  4'd3, 1'b1}
    };

    logic                     clk;
    logic                     rst;
    logic                     in_valid;
    logic                     in_row_start;
    logic [WORD_W-1:0]        in_word;
    logic                     thr_we;
    logic [PIX_W-1:0]         thr_data;
    logic                     out_valid;
    logic [NUM_TPL*CNT_W-1:0] out_count;

    probe_scorer u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_row_start (in_row_start),
        .in_word      (in_word),
        .thr_we       (thr_we),
        .thr_data     (thr_data),
        .out_valid    (out_valid),
        .out_count    (out_count)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int    img [WIN_ROWS][IMG_COLS];
    int    cur_thr;
    int    exp_q [MAX_Q][NUM_TPL];
    int    wr_ptr = 0;
    int    rd_ptr = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    function automatic int model_count(input int t, input int base);
        int n;
        n = 0;
        for (int p = 0; p < NUM_PROBES; p++) begin
            if (PROBE_TABLE[p].members[t]) begin
                int d;
                d = img[int'(PROBE_TABLE[p].rb)][base + int'(PROBE_TABLE[p].cb)]
                  - img[int'(PROBE_TABLE[p].ra)][base + int'(PROBE_TABLE[p].ca)];
                if (d > cur_thr || d < -cur_thr) n++;
            end
        end
        return n;
    endfunction

    function automatic int pattern_pix(input int pat, input int r, input int c);
        case (pat)
            0:       return 2048;
            1:       return (r * 517 + c * 333) % 4096;
            2:       return ((r + c) % 2 == 1) ? 4095 : 0;
            default: return (r * r * 131 + c * 977 + 55) % 4096;
        endcase
    endfunction

    task automatic push_expected(input int base);
        for (int t = 0; t < NUM_TPL; t++) begin
            exp_q[wr_ptr % MAX_Q][t] = model_count(t, base);
        end
        wr_ptr++;
    endtask

    // Drive one cycle: inputs change just after a falling edge.
    task automatic put(input logic v, input logic [31:0] w, input logic rs);
        in_valid     = v;
        in_word      = w;
        in_row_start = rs;
        @(negedge clk);
        #1;
    endtask

    task automatic write_thr(input int v);
        thr_we   = 1'b1;
        thr_data = 12'(v);
        cur_thr  = v;
        put(1'b0, 32'h0, 1'b0);
        thr_we   = 1'b0;
    endtask

    task automatic drain();
        repeat (6) put(1'b0, 32'h0, 1'b0);
    endtask

    task automatic fill_pattern(input int pat);
        for (int r = 0; r < WIN_ROWS; r++) begin
            for (int c = 0; c < IMG_COLS; c++) img[r][c] = pattern_pix(pat, r, c);
        end
    endtask

    // Feed ncols columns of img as a new row; optional threshold switch on
    // the completing word of column sw_col. Pad nibbles carry junk (R2).
    task automatic send_band(input int ncols, input bit gap, input int sw_col, input int sw_thr);
        for (int c = 0; c < ncols; c++) begin
            for (int k = 0; k < WORDS_PER_COL; k++) begin
                logic [31:0] w;
                int          lo, hi;
                bit          last;
                lo   = img[2*k][c];
                hi   = (2*k + 1 < WIN_ROWS) ? img[2*k+1][c] : 0;
                w    = {4'(c + k + 5), 12'(hi), 4'(c * 3 + k + 9), 12'(lo)};
                last = (k == WORDS_PER_COL - 1);
                if (last && c == sw_col) begin
                    thr_we   = 1'b1;
                    thr_data = 12'(sw_thr);
                    cur_thr  = sw_thr;
                end
                if (last && c >= WIN_COLS - 1) push_expected(c - WIN_COLS + 1);
                put(1'b1, w, (c == 0 && k == 0));
                thr_we = 1'b0;
                if (gap) put(1'b0, 32'hFFFF_FFFF, 1'b1);
            end
        end
    endtask

    // Ordered comparison of every result strobe against the queued model.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd_ptr == wr_ptr) begin
                checks++;
                errors++;
                $display("FAIL R7 %s: out_valid actual 1 expected 0 (no window due)", cur_tag);
            end else begin
                for (int t = 0; t < NUM_TPL; t++) begin
                    int got, want;
                    got  = int'(out_count[t*CNT_W +: CNT_W]);
                    want = exp_q[rd_ptr % MAX_Q][t];
                    checks++;
                    if (got != want) begin
                        errors++;
                        $display("FAIL %s tpl %0d: count actual %0d expected %0d",
                                 cur_tag, t, got, want);
                    end
                end
                rd_ptr++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst          = 1'b1;
        in_valid     = 1'b0;
        in_row_start = 1'b0;
        in_word      = '0;
        thr_we       = 1'b0;
        thr_data     = '0;
        cur_thr      = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;

        // R1: idle outputs after reset
        checks++;
        if (out_valid !== 1'b0 || out_count !== '0) begin
            errors++;
            $display("FAIL R1: reset outputs actual valid=%0b count=%0h expected 0/0",
                     out_valid, out_count);
        end

        // Vector table: R1 (vector 0 relies on reset threshold 0), R2, R3, R4, R5
        for (int i = 0; i < NVEC; i++) begin
            cur_tag = "R2 R3 R4 R5 vector";
            if (i > 0) write_thr(int'(VEC[i][16:5]));
            else       cur_tag = "R1 R3 R5 reset threshold";
            fill_pattern(int'(VEC[i][4:1]));
            send_band(IMG_COLS - 1, VEC[i][0], -1, 0);
            drain();
        end

        // R4: differences exactly at the threshold do not fire, one past does
        cur_tag = "R4 strict boundary";
        write_thr(50);
        fill_pattern(0);
        img[3][2] = 2048 + 50;
        img[2][1] = 2048 - 51;
        img[0][3] = 2048 - 50;
        img[3][5] = 2048 + 51;
        send_band(IMG_COLS, 1'b0, -1, 0);
        drain();

        // R9: all probes fire, largest template reaches its full count
        cur_tag = "R9 full count";
        write_thr(0);
        for (int r = 0; r < WIN_ROWS; r++) begin
            for (int c = 0; c < IMG_COLS; c++) img[r][c] = (r * 16 + c) * 60;
        end
        send_band(IMG_COLS, 1'b0, -1, 0);
        drain();

        // R8: threshold switched on the completing word of column 5
        cur_tag = "R8 threshold switch";
        write_thr(4000);
        fill_pattern(3);
        send_band(IMG_COLS, 1'b0, 5, 200);
        drain();

        // R7: back-to-back rows, second row restarts window fill
        cur_tag = "R7 row restart";
        fill_pattern(1);
        send_band(6, 1'b0, -1, 0);
        fill_pattern(3);
        send_band(6, 1'b1, -1, 0);
        drain();

        // R6: strobe due exactly 3 edges after the completing word
        cur_tag = "R6 latency";
        fill_pattern(2);
        send_band(WIN_COLS, 1'b0, -1, 0);
        put(1'b0, 32'h0, 1'b0);
        put(1'b0, 32'h0, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R6: out_valid after 2 edges actual %0b expected 0", out_valid);
        end
        put(1'b0, 32'h0, 1'b0);
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R6: out_valid after 3 edges actual %0b expected 1", out_valid);
        end
        drain();

        // R6: every scored window was reported
        checks++;
        if (rd_ptr != wr_ptr) begin
            errors++;
            $display("FAIL R6: results delivered actual %0d expected %0d", rd_ptr, wr_ptr);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule